// File: doc/BRIEF.md
# Multichannel DAC Double-Buffered Register Interface

This block is the bus-side register logic for a bank of 16-bit digital-to-analog converter channels on a byte-wide I/O bus. Each channel owns two consecutive byte addresses inside a window placed by a switch-set base value. Byte writes land in a per-channel input latch that holds a low half and a high half. The latched code reaches the channel's output register, which drives the converter, in one of two ways.

In individual mode, a write to a channel's high byte commits the new high byte, together with the low byte already held, to that channel's output. In simultaneous mode, writes only fill the latches. Any read that falls inside the window then copies every latch into its output register at the same clock edge, so all channels move together.

On reset, both the latches and the outputs load a code that gives 0 V. That code is 0x0000 for unipolar wiring and 0x8000 for bipolar wiring. Reads return 0x00 and serve only as the transfer trigger.

Top module: `dac_bus_regs`

## Requirements
- R1: While rst_n is low at a rising edge with bipolar_sel = 0, every channel output becomes 0x0000.
- R2: While rst_n is low at a rising edge with bipolar_sel = 1, every channel output becomes 0x8000.
- R3: A write to a channel's low byte (address base + 2n) changes no channel output, in either mode.
- R4: In individual mode (sim_mode = 0), a write of byte H to address base + 2n + 1 sets channel n's output to {H, held low byte} in the cycle after the write. A second high write reuses the same held low byte. No other channel changes.
- R5: Channel n is decoded at byte offsets 2n (bits 7:0) and 2n + 1 (bits 15:8) of the window. This includes the last channel at offsets 30 and 31.
- R6: In simultaneous mode (sim_mode = 1), byte writes change no output.
- R7: In simultaneous mode, a read of any address in the window copies every channel's latched 16-bit code to its output in the cycle after the read.
- R8: In individual mode, a read changes no output.
- R9: A write or read whose address lies outside the window changes no output, no latch, and starts no transfer.
- R10: rdata is 0x00 at all times, including during reads inside the window.
- R11: Reset also loads the input latches with the reset code. A simultaneous transfer of channels that were never written therefore yields 0x0000 or 0x8000.
- R12: The window spans byte addresses base_sel * 2 * NUM_CH through base_sel * 2 * NUM_CH + 2 * NUM_CH - 1. With base_sel = 31, that is the top window 0x3E0 to 0x3FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; strobes sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| base_sel | input | ADDR_W - log2(2*NUM_CH) | Switch value placing the window; base = base_sel * 2 * NUM_CH |
| bipolar_sel | input | 1 | Reset code select: 0 gives 0x0000, 1 gives 0x8000 |
| sim_mode | input | 1 | 0 = commit per channel on high-byte write, 1 = commit all channels on an in-window read |
| wr_en | input | 1 | Single-cycle byte write strobe |
| rd_en | input | 1 | Single-cycle byte read strobe |
| addr | input | ADDR_W | Byte address on the I/O bus |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, always 0x00 |
| ch_code | output | 16*NUM_CH | Output codes; channel n occupies bits 16n+15:16n |

## Verification
The bench builds the block with its defaults: 16 channels and a 10-bit address. This makes the 32-byte window, the last channel at offsets 30 and 31, and both the 0x300 and the topmost 0x3E0 window positions reachable. Stimulus lands one byte below and one byte above each window to probe the decode edges. Both reset polarities are exercised, each followed by a simultaneous transfer over channels that were never written. A mode change with latches that differ from the outputs shows that reads move data only in simultaneous mode.

// File: rtl/dac_regs_pkg.sv
// Package: shared constants and types for the DAC register interface.
// Assumes a byte-wide data bus and converter codes of two bytes.
package dac_regs_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 2 * BYTE_W;

    // Which half of a channel code an address selects (address bit 0).
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    // Code that yields 0 V out of reset: mid-scale for bipolar, zero for unipolar.
    function automatic logic [CODE_W-1:0] zero_volt_code(input logic bipolar);
        zero_volt_code = bipolar ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    endfunction
endpackage

// File: rtl/dac_addr_decode.sv
// Module: dac_addr_decode
// Decodes a byte address against the switch-selected window.
// It produces a window hit, the channel index and the half (low or high byte).
// Assumes NUM_CH is a power of two of at least 2 and the window is aligned to its size.
module dac_addr_decode
    import dac_regs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NUM_CH = 16,
    localparam int OFF_W = $clog2(2 * NUM_CH),
    localparam int CH_W  = OFF_W - 1,
    localparam int SEL_W = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SEL_W-1:0]  base_sel,
    output logic              hit,
    output logic [CH_W-1:0]   ch_idx,
    output half_e             half
);
    // Compare upper address bits with the switches; split the offset into channel and half.
    always_comb begin
        hit    = (addr[ADDR_W-1:OFF_W] == base_sel);
        ch_idx = addr[OFF_W-1:1];
        half   = half_e'(addr[0]);
    end
endmodule

// File: rtl/dac_xfer_ctrl.sv
// Module: dac_xfer_ctrl
// Turns a decoded bus strobe into per-channel latch enables and commit controls.
// Assumes wr_en and rd_en are single-cycle strobes that are never high together.
module dac_xfer_ctrl
    import dac_regs_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              hit,
    input  logic [CH_W-1:0]   ch_idx,
    input  half_e             half,
    input  logic              sim_mode,
    output logic [NUM_CH-1:0] lo_we,
    output logic [NUM_CH-1:0] hi_we,
    output logic [NUM_CH-1:0] hi_commit,
    output logic              xfer_all
);
    logic wr_hit;

    // A write counts only when it falls inside the window.
    always_comb wr_hit = wr_en && hit;

    // A read inside the window in simultaneous mode moves every channel.
    always_comb xfer_all = rd_en && hit && sim_mode;

    // One enable set per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_en
        logic sel;
        always_comb begin
            sel          = wr_hit && (ch_idx == CH_W'(c));
            lo_we[c]     = sel && (half == HALF_LO);
            hi_we[c]     = sel && (half == HALF_HI);
            hi_commit[c] = sel && (half == HALF_HI) && !sim_mode;
        end
    end
endmodule

// File: rtl/dac_chan_reg.sv
// Module: dac_chan_reg
// Holds one channel's double buffer: a two-byte input latch and the output register.
// Assumes hi_commit and xfer are never high together (they come from a write and a read).
module dac_chan_reg
    import dac_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rst_code,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic              hi_commit,
    input  logic              xfer,
    output logic [CODE_W-1:0] out_code
);
    logic [BYTE_W-1:0] lo_q;
    logic [BYTE_W-1:0] hi_q;

    // Input latch: capture the addressed byte; reset to the 0 V code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= rst_code[BYTE_W-1:0];
            hi_q <= rst_code[CODE_W-1:BYTE_W];
        end else begin
            if (lo_we) lo_q <= byte_in;
            if (hi_we) hi_q <= byte_in;
        end
    end

    // Output register: take the new word on a high-byte commit or the latch on a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)         out_code <= rst_code;
        else if (hi_commit) out_code <= {byte_in, lo_q};
        else if (xfer)      out_code <= {hi_q, lo_q};
    end

    AST_RST_CODE: assert property (@(posedge clk)
        !rst_n |=> (out_code == $past(rst_code)) && ({hi_q, lo_q} == $past(rst_code))); // R11
    AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we |=> $stable(out_code)); // R3
    AST_HI_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        hi_commit |=> out_code == {$past(byte_in), $past(lo_q)}); // R4
    AST_XFER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !hi_commit) |=> out_code == {$past(hi_q), $past(lo_q)}); // R7
endmodule

// File: rtl/dac_bus_regs.sv
// Module: dac_bus_regs (top)
// Byte-bus register interface for NUM_CH double-buffered 16-bit DAC channels.
// Channel n sits at base + 2n (low byte) and base + 2n + 1 (high byte).
// Assumes single-cycle wr_en/rd_en strobes and a synchronous active-low reset.
module dac_bus_regs
    import dac_regs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NUM_CH = 16,
    localparam int OFF_W = $clog2(2 * NUM_CH),
    localparam int CH_W  = OFF_W - 1,
    localparam int SEL_W = ADDR_W - OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SEL_W-1:0]         base_sel,
    input  logic                     bipolar_sel,
    input  logic                     sim_mode,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    output logic [NUM_CH*CODE_W-1:0] ch_code
);
    logic              hit;
    logic [CH_W-1:0]   ch_idx;
    half_e             half;
    logic [NUM_CH-1:0] lo_we;
    logic [NUM_CH-1:0] hi_we;
    logic [NUM_CH-1:0] hi_commit;
    logic              xfer_all;
    logic [CODE_W-1:0] rst_code;

    // Reset code picked by the unipolar/bipolar select.
    always_comb rst_code = zero_volt_code(bipolar_sel);

    // Reads carry no data; they only trigger transfers.
    always_comb rdata = '0;

    dac_addr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) dec_i (
        .addr     (addr),
        .base_sel (base_sel),
        .hit      (hit),
        .ch_idx   (ch_idx),
        .half     (half)
    );

    dac_xfer_ctrl #(.NUM_CH(NUM_CH)) ctl_i (
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .hit       (hit),
        .ch_idx    (ch_idx),
        .half      (half),
        .sim_mode  (sim_mode),
        .lo_we     (lo_we),
        .hi_we     (hi_we),
        .hi_commit (hi_commit),
        .xfer_all  (xfer_all)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dac_chan_reg chan_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .rst_code  (rst_code),
            .byte_in   (wdata),
            .lo_we     (lo_we[c]),
            .hi_we     (hi_we[c]),
            .hi_commit (hi_commit[c]),
            .xfer      (xfer_all),
            .out_code  (ch_code[c*CODE_W +: CODE_W])
        );
    end

    AST_SIM_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sim_mode && !(rd_en && hit)) |=> $stable(ch_code)); // R6
    AST_IND_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sim_mode && !wr_en) |=> $stable(ch_code)); // R8
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> $stable(ch_code)); // R9
    AST_ONE_CH_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lo_we | hi_we)); // R5
endmodule

// File: tb/dac_bus_regs_tb_top.sv
`timescale 1ns/1ps
module dac_bus_regs_tb_top;
    localparam int NCH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  base_sel = 5'd24;
    logic        bipolar_sel = 1'b0;
    logic        sim_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [NCH*16-1:0] ch_code;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [15:0] exp_out [NCH];
    logic [7:0]  exp_lo  [NCH];
    logic [7:0]  exp_hi  [NCH];

    always #2 clk = ~clk;

    dac_bus_regs dut_i (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .bipolar_sel(bipolar_sel),
        .sim_mode(sim_mode), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ch_code(ch_code)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int c = 0; c < NCH; c++) check(req, ch_code[c*16 +: 16], exp_out[c]);
    endtask

    function automatic bit in_win(input logic [9:0] a);
        return (int'(a) >= int'(base_sel) * 32) && (int'(a) < int'(base_sel) * 32 + 32);
    endfunction

    task automatic do_reset(input logic bip);
        @(negedge clk);
        rst_n = 1'b0; bipolar_sel = bip;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NCH; c++) begin
            exp_out[c] = bip ? 16'h8000 : 16'h0000;
            exp_lo[c]  = exp_out[c][7:0];
            exp_hi[c]  = exp_out[c][15:8];
        end
    endtask

    task automatic bus_wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (in_win(a)) begin
            int c = (int'(a) - int'(base_sel) * 32) / 2;
            if (a[0]) begin
                exp_hi[c] = d;
                if (!sim_mode) exp_out[c] = {d, exp_lo[c]};
            end else exp_lo[c] = d;
        end
    endtask

    task automatic bus_rd(input logic [9:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 check("R10", {8'h00, rdata}, 16'h0000);
        @(negedge clk);
        rd_en = 1'b0;
        if (in_win(a) && sim_mode)
            for (int c = 0; c < NCH; c++) exp_out[c] = {exp_hi[c], exp_lo[c]};
    endtask

    task automatic t_reset_uni();
        base_sel = 5'd24;
        do_reset(1'b0);
        check_all("R1");
    endtask

    task automatic t_individual();
        sim_mode = 1'b0;
        bus_wr(10'h306, 8'h34);
        check_all("R3");
        bus_wr(10'h307, 8'h12);
        check("R4", ch_code[3*16 +: 16], 16'h1234);
        check_all("R4");
        bus_wr(10'h307, 8'hAB);
        check("R4", ch_code[3*16 +: 16], 16'hAB34);
        bus_wr(10'h31E, 8'hCD);
        bus_wr(10'h31F, 8'hEF);
        check("R5", ch_code[15*16 +: 16], 16'hEFCD);
        bus_wr(10'h300, 8'h99);
        check_all("R3");
    endtask

    task automatic t_ind_read();
        sim_mode = 1'b0;
        bus_wr(10'h302, 8'h55);
        bus_rd(10'h305);
        check_all("R8");
    endtask

    task automatic t_outside();
        sim_mode = 1'b0;
        bus_wr(10'h321, 8'h77);
        bus_wr(10'h2FF, 8'h66);
        check_all("R9");
    endtask

    task automatic t_simul();
        sim_mode = 1'b1;
        bus_wr(10'h300, 8'h11);
        bus_wr(10'h301, 8'h22);
        bus_wr(10'h30E, 8'h33);
        bus_wr(10'h30F, 8'h44);
        check_all("R6");
        bus_rd(10'h2FF);
        check_all("R9");
        bus_rd(10'h320);
        check_all("R9");
        bus_rd(10'h30B);
        check("R7", ch_code[0*16 +: 16], 16'h2211);
        check("R7", ch_code[7*16 +: 16], 16'h4433);
        check("R7", ch_code[1*16 +: 16], 16'h0055);
        check_all("R7");
    endtask

    task automatic t_bipolar();
        do_reset(1'b1);
        check_all("R2");
        sim_mode = 1'b1;
        bus_wr(10'h305, 8'h3C);
        check_all("R6");
        bus_rd(10'h31F);
        check("R11", ch_code[2*16 +: 16], 16'h3C00);
        check("R11", ch_code[9*16 +: 16], 16'h8000);
        check_all("R11");
    endtask

    task automatic t_top_window();
        base_sel = 5'd31;
        sim_mode = 1'b0;
        bus_wr(10'h3FE, 8'h01);
        bus_wr(10'h3FF, 8'hF0);
        check("R12", ch_code[15*16 +: 16], 16'hF001);
        bus_wr(10'h3E1, 8'h5A);
        check("R12", ch_code[0*16 +: 16], 16'h5A00);
        bus_wr(10'h3DF, 8'hA5);
        check_all("R9");
    endtask

    initial begin
        t_reset_uni();
        t_individual();
        t_ind_read();
        t_outside();
        t_simul();
        t_bipolar();
        t_top_window();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule